// File: doc/BRIEF.md
# Linked-List Descriptor Walker for a Storage DMA

This block is the DMA sequencer of a storage host. It reads a list of
16-byte descriptors from system memory and moves each one's buffers
between memory and the data FIFO that faces the card. Data flows in one
of two directions. In the card-bound direction it reads words from memory
and pushes them into the FIFO. In the memory-bound direction it pops
words from the FIFO and writes them to memory. The memory port makes one
32-bit access at a time, with a request/acknowledge handshake. The FIFO
side is a plain valid/ready pair in each direction.

Software writes the list's start address and the transfer length in bytes,
sets the enable, and pulses start. For each descriptor the walker does the
following in order:

- It reads the flag word and checks that the DMA owns the descriptor.
- It reads the rest of the descriptor.
- It moves the first buffer, then the second buffer if that buffer is in use.
- It writes the flag word back with ownership cleared.
- It steps to the next descriptor.

If a descriptor is not owned, the walker parks and raises a flag. A later
start re-reads that same descriptor. A soft reset pulse aborts any walk.

States and transitions:

- IDLE goes to FETCH on an enabled start.
- FETCH reads four words.
  - It goes to HALT if the first word lacks ownership.
  - Otherwise it goes to SEGMENT.
- SEGMENT loads the next buffer.
  - It goes to MEM_RD when the transfer is card-bound.
  - It goes to FIFO_GET when the transfer is memory-bound.
  - It stays in SEGMENT when the buffer is empty.
  - It goes to WBACK after the second buffer.
- MEM_RD goes to FIFO_PUT. FIFO_PUT goes back to MEM_RD, or to SEGMENT after the buffer's last word.
- FIFO_GET goes to MEM_WR. MEM_WR goes back to FIFO_GET, or to SEGMENT after the buffer's last word.
- WBACK goes to IDLE on a last-segment descriptor, otherwise to ADVANCE.
- ADVANCE goes to FETCH.
- HALT goes to FETCH on an enabled start.
- Any state goes to SRST on a soft reset. SRST goes to IDLE one cycle later.

Top module: `dmaw_walker`

## Requirements
- R1: When `en` is high and the walker is idle, a `start` pulse loads `list_base` and begins fetching there. A `start` while `en` is low is ignored: `busy` and `mem_req` stay low.
- R2: A descriptor is four words at byte offsets 0, 4, 8 and 12.
  - Word 0 holds the flags: bit 31 ownership, bit 5 end of ring, bit 4 chained, bit 3 first segment, bit 2 last segment, bit 1 interrupt suppress.
  - Word 1 holds the buffer sizes: bits 12:0 are size A and bits 25:13 are size B, both in bytes.
  - Word 2 is the address of buffer A.
  - Word 3 is either the address of buffer B or the link to the next descriptor.
- R3: If word 0 is fetched with bit 31 clear, the walker stops without touching memory further. It sets `desc_unavail` and drops `busy`.
- R4: After a descriptor's buffers are moved, its word 0 is rewritten with bit 31 cleared and all other bits unchanged.
- R5: Buffer A (ceil(size A/4) words) is moved before buffer B. Buffer B is at the word-3 address and is moved only when the chained flag is clear. With the chained flag set, size B is ignored.
- R6: The next descriptor address is chosen in this order:
  - With end of ring set, it is `list_base`. This holds even if chained is also set.
  - Otherwise, with chained set, it is word 3.
  - Otherwise, it is the current address plus 16.
- R7: The whole walk moves at most ceil(`byte_count`/4) words. Buffers are cut short once that budget is used.
- R8: Completing a descriptor sets `xfer_done` unless its bit 1 is set. A descriptor with the last-segment flag ends the walk. `xfer_done` and `desc_unavail` clear on the next start.
- R9: With `to_card` = 1, memory words are presented on `tx_data`. With `to_card` = 0, words accepted from `rx_data` are written to memory at rising buffer addresses.
- R10: A `soft_rst` pulse aborts the walk without write-back. It clears both flags, and `reset_busy` is high for exactly the following cycle.
- R11: A start while halted re-fetches the same descriptor address rather than `list_base`.
- R12: A memory request keeps its address until acknowledged, and `tx_valid` keeps its data until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| start | input | 1 | Start or resume pulse |
| soft_rst | input | 1 | Soft reset pulse |
| to_card | input | 1 | 1: memory to FIFO, 0: FIFO to memory |
| list_base | input | AW | Descriptor list start address |
| byte_count | input | BCW | Total transfer length in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| tx_valid | output | 1 | Word offered to FIFO |
| tx_data | output | 32 | FIFO-bound word |
| tx_ready | input | 1 | FIFO accepts word |
| rx_valid | input | 1 | FIFO offers word |
| rx_data | input | 32 | FIFO word |
| rx_ready | output | 1 | Walker accepts word |
| busy | output | 1 | Walk in progress |
| desc_unavail | output | 1 | Stopped on an unowned descriptor |
| xfer_done | output | 1 | Descriptor completion flag |
| reset_busy | output | 1 | Soft reset in progress |

## Verification
The bench goes after each of these corner cases:

- **Chained descriptor with a nonzero size B.** A walker that honoured size B would emit extra words.
- **Descriptor with both end of ring and chained set.** A walker with the wrong priority would follow the link and emit a buffer that is never expected.
- **Byte count smaller than the buffer.** An unclamped walker would emit too many words.
- **Descriptor walked twice around a ring.** Stale ownership would make the walker loop forever instead of halting after its own write-back.
- **Resume from halt.** A walker that reloaded the list base would emit the wrong buffer.
- **Soft reset during a FIFO stall.** A walker that wrote back anyway would leave ownership cleared.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    localparam int WORD_W     = 32;
    localparam int SIZE_W     = 13;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = DESC_WORDS * 4;

    localparam int OWN_BIT   = 31;
    localparam int CERR_BIT  = 30;
    localparam int RING_BIT  = 5;
    localparam int CHAIN_BIT = 4;
    localparam int FIRST_BIT = 3;
    localparam int LAST_BIT  = 2;
    localparam int NOIRQ_BIT = 1;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_SEGMENT, S_MEM_RD, S_FIFO_PUT,
        S_FIFO_GET, S_MEM_WR, S_WBACK, S_ADVANCE, S_HALT, S_SRST
    } walk_state_e;

    typedef struct packed {
        logic              own;
        logic              card_err;
        logic              ring_end;
        logic              chained;
        logic              first;
        logic              last;
        logic              irq_off;
        logic [SIZE_W-1:0] size_a;
        logic [SIZE_W-1:0] size_b;
        logic [WORD_W-1:0] buf_a;
        logic [WORD_W-1:0] link;
    } desc_t;

endpackage

// File: rtl/dmaw_desc_decode.sv
module dmaw_desc_decode
    import dmaw_pkg::*;
(
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output desc_t                             d
);
    always_comb begin
        d.own      = words[0][OWN_BIT];
        d.card_err = words[0][CERR_BIT];
        d.ring_end = words[0][RING_BIT];
        d.chained  = words[0][CHAIN_BIT];
        d.first    = words[0][FIRST_BIT];
        d.last     = words[0][LAST_BIT];
        d.irq_off  = words[0][NOIRQ_BIT];
        d.size_a   = words[1][SIZE_W-1:0];
        d.size_b   = words[1][2*SIZE_W-1:SIZE_W];
        d.buf_a    = words[2];
        d.link     = words[3];
    end
endmodule

// File: rtl/dmaw_next_addr.sv
module dmaw_next_addr #(
    parameter int AW   = 32,
    parameter int STEP = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] link,
    input  logic [AW-1:0] base,
    input  logic          ring_end,
    input  logic          chained,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STRIDE = AW'(STEP);

    always_comb begin
        if (ring_end)     nxt = base;
        else if (chained) nxt = link;
        else              nxt = cur + STRIDE;
    end
endmodule

// File: rtl/dmaw_seg_len.sv
module dmaw_seg_len #(
    parameter int SZW = 13,
    parameter int CW  = 15
) (
    input  logic [SZW-1:0] size_bytes,
    input  logic [CW-1:0]  budget,
    output logic [CW-1:0]  words
);
    localparam int SW   = SZW - 1;
    localparam int MW   = (SW > CW) ? SW : CW;

    logic [SZW:0]  rounded;
    logic [MW-1:0] need_w;
    logic [MW-1:0] have_w;
    logic [MW-1:0] pick;

    always_comb begin
        rounded = {1'b0, size_bytes} + (SZW+1)'(3);
        need_w  = MW'(rounded[SZW:2]);
        have_w  = MW'(budget);
        pick    = (need_w < have_w) ? need_w : have_w;
        words   = pick[CW-1:0];
    end
endmodule

// File: rtl/dmaw_walker.sv
module dmaw_walker
    import dmaw_pkg::*;
#(
    parameter int AW  = 32,
    parameter int BCW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              soft_rst,
    input  logic              to_card,
    input  logic [AW-1:0]     list_base,
    input  logic [BCW-1:0]    byte_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              busy,
    output logic              desc_unavail,
    output logic              xfer_done,
    output logic              reset_busy
);
    localparam int WCW = BCW - 1;
    localparam logic [AW-1:0]     WSTEP    = AW'(4);
    localparam logic [WCW-1:0]    ONE_W    = WCW'(1);
    localparam logic [WORD_W-1:0] OWN_MASK = ~(WORD_W'(1) << OWN_BIT);

    walk_state_e state, nxt_state;

    logic [DESC_WORDS-1:0][WORD_W-1:0] dw_q;
    logic [AW-1:0]     desc_addr, base_q, ptr, nxt_desc, seg_base;
    logic [1:0]        widx, seg;
    logic [WCW-1:0]    seg_left, budget, seg_words;
    logic [SIZE_W-1:0] seg_size;
    logic [WORD_W-1:0] hold;
    logic              unavail_q, irq_q;
    logic [BCW:0]      bc_round;
    desc_t             d;

    dmaw_desc_decode u_dec (.words(dw_q), .d(d));

    dmaw_next_addr #(.AW(AW), .STEP(DESC_BYTES)) u_nxt (
        .cur(desc_addr), .link(d.link[AW-1:0]), .base(base_q),
        .ring_end(d.ring_end), .chained(d.chained), .nxt(nxt_desc)
    );

    always_comb begin
        seg_size = (seg == 2'd0) ? d.size_a : (d.chained ? '0 : d.size_b);
        seg_base = (seg == 2'd0) ? d.buf_a[AW-1:0] : d.link[AW-1:0];
        bc_round = {1'b0, byte_count} + (BCW+1)'(3);
    end

    dmaw_seg_len #(.SZW(SIZE_W), .CW(WCW)) u_len (
        .size_bytes(seg_size), .budget(budget), .words(seg_words)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            S_IDLE:     if (start && en) nxt_state = S_FETCH;
            S_FETCH:    if (mem_ack) begin
                            if (widx == 2'd0 && !mem_rdata[OWN_BIT]) nxt_state = S_HALT;
                            else if (widx == 2'd3)                   nxt_state = S_SEGMENT;
                        end
            S_SEGMENT:  if (seg == 2'd2)          nxt_state = S_WBACK;
                        else if (seg_words != '0) nxt_state = to_card ? S_MEM_RD : S_FIFO_GET;
            S_MEM_RD:   if (mem_ack)  nxt_state = S_FIFO_PUT;
            S_FIFO_PUT: if (tx_ready) nxt_state = (seg_left == ONE_W) ? S_SEGMENT : S_MEM_RD;
            S_FIFO_GET: if (rx_valid) nxt_state = S_MEM_WR;
            S_MEM_WR:   if (mem_ack)  nxt_state = (seg_left == ONE_W) ? S_SEGMENT : S_FIFO_GET;
            S_WBACK:    if (mem_ack)  nxt_state = d.last ? S_IDLE : S_ADVANCE;
            S_ADVANCE:  nxt_state = S_FETCH;
            S_HALT:     if (start && en) nxt_state = S_FETCH;
            S_SRST:     nxt_state = S_IDLE;
            default:    nxt_state = S_IDLE;
        endcase
        if (soft_rst) nxt_state = S_SRST;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dw_q      <= '0;
            desc_addr <= '0;
            base_q    <= '0;
            ptr       <= '0;
            widx      <= '0;
            seg       <= '0;
            seg_left  <= '0;
            budget    <= '0;
            hold      <= '0;
            unavail_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (soft_rst || state == S_SRST) begin
            widx      <= '0;
            seg       <= '0;
            unavail_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start && en) begin
                    desc_addr <= list_base;
                    base_q    <= list_base;
                    budget    <= bc_round[BCW:2];
                    widx      <= '0;
                    unavail_q <= 1'b0;
                    irq_q     <= 1'b0;
                end
                S_FETCH: if (mem_ack) begin
                    dw_q[widx] <= mem_rdata;
                    widx       <= widx + 2'd1;
                    seg        <= '0;
                    if (widx == 2'd0 && !mem_rdata[OWN_BIT]) unavail_q <= 1'b1;
                end
                S_SEGMENT: if (seg != 2'd2) begin
                    ptr      <= seg_base;
                    seg_left <= seg_words;
                    seg      <= seg + 2'd1;
                end
                S_MEM_RD: if (mem_ack) hold <= mem_rdata;
                S_FIFO_PUT: if (tx_ready) begin
                    ptr      <= ptr + WSTEP;
                    seg_left <= seg_left - ONE_W;
                    budget   <= budget - ONE_W;
                end
                S_FIFO_GET: if (rx_valid) hold <= rx_data;
                S_MEM_WR: if (mem_ack) begin
                    ptr      <= ptr + WSTEP;
                    seg_left <= seg_left - ONE_W;
                    budget   <= budget - ONE_W;
                end
                S_WBACK: if (mem_ack && !d.irq_off) irq_q <= 1'b1;
                S_ADVANCE: begin
                    desc_addr <= nxt_desc;
                    widx      <= '0;
                end
                S_HALT: if (start && en) begin
                    widx      <= '0;
                    unavail_q <= 1'b0;
                    irq_q     <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = hold;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + {{(AW-4){1'b0}}, widx, 2'b00};
            end
            S_MEM_RD: mem_req = 1'b1;
            S_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = dw_q[0] & OWN_MASK;
            end
            default: ;
        endcase
        tx_valid     = (state == S_FIFO_PUT);
        tx_data      = hold;
        rx_ready     = (state == S_FIFO_GET);
        busy         = !(state inside {S_IDLE, S_HALT, S_SRST});
        reset_busy   = (state == S_SRST);
        desc_unavail = unavail_q;
        xfer_done    = irq_q;
    end

endmodule

// File: rtl/dmaw_walker_chk.sv
module dmaw_walker_chk
    import dmaw_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input walk_state_e       state,
    input logic [1:0]        widx,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [AW-1:0]     mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [WORD_W-1:0] tx_data,
    input logic              busy,
    input logic              desc_unavail,
    input logic              reset_busy
);
    AST_WBACK_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WBACK && mem_req) |-> (mem_we && !mem_wdata[OWN_BIT])); // R4

    AST_UNOWNED_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && widx == 2'd0 && mem_ack && !mem_rdata[OWN_BIT] && !soft_rst)
        |=> (desc_unavail && !busy && !mem_req)); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !soft_rst) |=> (mem_req && $stable(mem_addr))); // R12

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data))); // R12

    AST_SRST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reset_busy && !busy && !desc_unavail)); // R10

    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_busy && !soft_rst) |=> !reset_busy); // R10
endmodule

bind dmaw_walker dmaw_walker_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .state(state), .widx(widx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .busy(busy),
    .desc_unavail(desc_unavail), .reset_busy(reset_busy)
);

// File: tb/dmaw_walker_test.sv
`timescale 1ns/1ps
module dmaw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1, start = 1'b0, soft_rst = 1'b0, to_card = 1'b1;
    logic [31:0] list_base = '0;
    logic [15:0] byte_count = 16'd64;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, rx_valid, rx_ready;
    logic [31:0] tx_data, rx_data;
    logic        busy, desc_unavail, xfer_done, reset_busy;

    logic [31:0] mem [64];
    logic [31:0] txbuf [32];
    int          txn, rxn;
    logic        clr = 1'b0, tx_rdy = 1'b1;
    int          n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    dmaw_walker uut (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .soft_rst(soft_rst),
        .to_card(to_card), .list_base(list_base), .byte_count(byte_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .busy(busy), .desc_unavail(desc_unavail), .xfer_done(xfer_done),
        .reset_busy(reset_busy)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];
    assign tx_ready  = tx_rdy;
    assign rx_valid  = 1'b1;
    assign rx_data   = 32'hC000 + rxn;

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (clr) begin
            txn <= 0;
            rxn <= 0;
        end else begin
            if (tx_valid && tx_ready) begin
                txbuf[txn[4:0]] <= tx_data;
                txn <= txn + 1;
            end
            if (rx_valid && rx_ready) rxn <= rxn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic fill_data();
        for (int i = 0; i < 16; i++) begin
            mem[32+i] = 32'hA000 + i;
            mem[48+i] = 32'hB000 + i;
        end
    endtask

    task automatic put_desc(input int w, input logic [31:0] f, input logic [31:0] s,
                            input logic [31:0] b, input logic [31:0] l);
        mem[w] = f; mem[w+1] = s; mem[w+2] = b; mem[w+3] = l;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run();
        pulse_start();
        for (int k = 0; k < 3000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // {word0, word1, byte_count, expected words, expected {unavail, irq}}
    localparam logic [159:0] TBL [5] = '{
        {32'h8000_001C, 32'h0001_0008, 32'd64, 32'd2, 32'd1},
        {32'h8000_000C, 32'h0000_8008, 32'd64, 32'd3, 32'd1},
        {32'h8000_0006, 32'h0000_0004, 32'd64, 32'd1, 32'd0},
        {32'h8000_000C, 32'h0000_0010, 32'd8,  32'd2, 32'd1},
        {32'h0000_000C, 32'h0000_0008, 32'd64, 32'd0, 32'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        fill_data();
        clear_counts();
        do_reset();

        // Reset state
        chk("reset busy", {31'd0, busy}, 32'd0);
        chk("reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("reset flags", {30'd0, desc_unavail, xfer_done}, 32'd0);
        chk("reset reset_busy", {31'd0, reset_busy}, 32'd0);

        // R1: start ignored while disabled
        put_desc(0, 32'h8000_0004, 32'h4, 32'h80, 32'h0);
        en = 1'b0;
        pulse_start();
        chk("R1 disabled busy", {31'd0, busy}, 32'd0);
        chk("R1 disabled mem_req", {31'd0, mem_req}, 32'd0);
        en = 1'b1;

        // Table of single-descriptor cases: R2 R4 R5 R7 R8 R3
        for (int i = 0; i < 5; i++) begin
            logic [31:0] w0, w1, bc, ew, ef;
            {w0, w1, bc, ew, ef} = TBL[i];
            do_reset();
            fill_data();
            put_desc(0, w0, w1, 32'h80, 32'hC0);
            byte_count = bc[15:0];
            list_base = '0;
            to_card = 1'b1;
            clear_counts();
            run();
            chk("R5 R7 word count", txn, ew);
            chk("R8 R3 flags", {30'd0, desc_unavail, xfer_done}, ef);
            chk("R4 write-back word0", mem[0], w0[31] ? (w0 & 32'h7FFF_FFFF) : w0);
            if (ew != 0) chk("R2 first word", txbuf[0], 32'hA000);
            if (ew == 3) chk("R5 buffer B word", txbuf[2], 32'hB000);
        end

        // R6: chained, then sequential, then last; address 0x10 holds a trap
        do_reset();
        fill_data();
        put_desc(0,  32'h8000_0018, 32'h4, 32'h80, 32'h20);
        put_desc(4,  32'h8000_0004, 32'h4, 32'hC0, 32'h0);
        put_desc(8,  32'h8000_0000, 32'h4, 32'h84, 32'hC0);
        put_desc(12, 32'h8000_0004, 32'h4, 32'h88, 32'hC0);
        byte_count = 16'd64;
        clear_counts();
        run();
        chk("R6 walk count", txn, 32'd3);
        chk("R6 walk order 1", txbuf[1], 32'hA001);
        chk("R6 walk order 2", txbuf[2], 32'hA002);
        chk("R4 chain owner cleared", {31'd0, mem[8][31]}, 32'd0);
        chk("R6 trap untouched", mem[4], 32'h8000_0004);

        // R6 end of ring beats chained; R3 second pass halts on own write-back
        do_reset();
        put_desc(0, 32'h8000_0030, 32'h4, 32'h80, 32'h20);
        put_desc(8, 32'h8000_0004, 32'h4, 32'hC0, 32'h0);
        clear_counts();
        run();
        chk("R6 ring count", txn, 32'd1);
        chk("R3 ring halt", {30'd0, desc_unavail, xfer_done}, 32'd3);
        chk("R6 link untouched", mem[8], 32'h8000_0004);

        // R11: resume from halt re-fetches the same descriptor
        mem[0] = 32'h8000_0004;
        mem[2] = 32'h84;
        list_base = 32'h20;
        clear_counts();
        run();
        chk("R11 resume count", txn, 32'd1);
        chk("R11 resume data", txbuf[0], 32'hA001);
        chk("R11 flags", {30'd0, desc_unavail, xfer_done}, 32'd1);
        list_base = '0;

        // R9: FIFO to memory
        do_reset();
        put_desc(0, 32'h8000_0004, 32'h8, 32'h90, 32'h0);
        to_card = 1'b0;
        clear_counts();
        run();
        chk("R9 rx word 0", mem[36], 32'hC000);
        chk("R9 rx word 1", mem[37], 32'hC001);
        chk("R9 rx count", rxn, 32'd2);
        to_card = 1'b1;

        // R10 / R12: soft reset during a FIFO stall
        do_reset();
        fill_data();
        put_desc(0, 32'h8000_0004, 32'h8, 32'h80, 32'h0);
        tx_rdy = 1'b0;
        pulse_start();
        repeat (8) @(negedge clk);
        chk("R12 stall valid", {31'd0, tx_valid}, 32'd1);
        chk("R12 stall data", tx_data, 32'hA000);
        soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        chk("R10 reset_busy high", {31'd0, reset_busy}, 32'd1);
        chk("R10 busy dropped", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R10 reset_busy one cycle", {31'd0, reset_busy}, 32'd0);
        chk("R10 no write-back", mem[0], 32'h8000_0004);
        chk("R10 flags clear", {30'd0, desc_unavail, xfer_done}, 32'd0);
        tx_rdy = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule